// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that each hold several independent integers packed side by side. A two-bit size code splits the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane is computed at the same time. Carry and borrow signals are cut at each lane edge.

Each request also selects the operation, the overflow policy and the number interpretation. The operation is add or subtract. The overflow policy is modular wraparound or clamping. The number interpretation is signed or unsigned. A single valid strobe captures the request. One clock later the registered result appears, together with a per-lane vector that marks which lanes were clamped.

The datapath is built from 8-bit slices. A slice passes its carry to the next slice only when the two slices belong to the same lane. Overflow is detected at the top slice of each lane, and that decision is then applied to every slice of the lane.

Top module: `simd_addsub`

## Requirements
- R1: `lane_size_i` selects the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Lane k occupies bits [k*W +: W] of each operand and of the result.
- R2: When `sub_i` = 0 every lane computes a+b. When `sub_i` = 1 every lane computes a-b. All lanes are computed in parallel.
- R3: No carry or borrow crosses a lane boundary. Carries do propagate between the 8-bit slices inside a wider lane.
- R4: When `sat_i` = 0 each lane result is the exact result modulo 2^W.
- R5: When `sat_i` = 1 and `signed_i` = 0, an add that overflows gives all-ones, and a subtract that underflows gives zero.
- R6: When `sat_i` = 1 and `signed_i` = 1, a lane that overflows toward positive gives the largest positive value (0x7F.., sign bit 0). A lane that overflows toward negative gives the most negative value (0x80..).
- R7: `valid_o` equals `in_valid_i` delayed by one clock. The result and the flags are captured only on a cycle with `in_valid_i` = 1 and otherwise hold their values.
- R8: `sat_flags_o` bit k is 1 exactly when lane k was clamped. Bits at or above the active lane count read 0. All bits read 0 in wraparound mode.
- R9: While `rst` is high at a clock edge, `valid_o`, `result_o` and `sat_flags_o` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request strobe |
| lane_size_i | input | 2 | Lane width code |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| sat_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| valid_o | output | 1 | Result strobe, one clock after request |
| result_o | output | 64 | Registered packed result |
| sat_flags_o | output | 8 | Per-lane clamp indicators |

## Verification
The bench places 0xFF in the lowest byte and adds one, in byte mode and in quad mode. A design that leaks a carry across a lane edge would disturb the neighbouring byte. A design that cuts carries inside a wide lane would lose the 0x100.

Signed vectors check both directions of overflow, and also a case that reaches exactly the most negative value without overflowing. An inverted clamp direction or an over-eager overflow test would produce the wrong limit there. Unsigned subtract underflow must give zero and not all-ones.

Flag vectors in the 16-bit and 32-bit modes check that each flag lands at the lane index and not at the byte index. A hold test with the strobe low checks that the result does not follow the changed operands.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/simd_byte_slice.sv
// One slice of the split adder: a + (b ^ inv) + cin.
module simd_byte_slice #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          inv,
  input  logic          cin,
  output logic [SW-1:0] sum,
  output logic          cout
);
  logic [SW:0] ext;
  always_comb begin
    ext  = {1'b0, a} + {1'b0, b ^ {SW{inv}}} + {{SW{1'b0}}, cin};
    sum  = ext[SW-1:0];
    cout = ext[SW];
  end
endmodule

// File: rtl/simd_lane_sat.sv
// Overflow decision for a lane, evaluated at its top slice.
module simd_lane_sat (
  input  logic a_msb,
  input  logic b_msb,
  input  logic r_msb,
  input  logic cout,
  input  logic sub,
  input  logic sgn,
  output logic ovf,
  output logic dir_hi
);
  always_comb begin
    if (sgn) begin
      ovf    = sub ? ((a_msb != b_msb) && (r_msb != a_msb))
                   : ((a_msb == b_msb) && (r_msb != a_msb));
      dir_hi = ~a_msb;
    end else begin
      ovf    = sub ? ~cout : cout;
      dir_hi = ~sub;
    end
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int SLICE_W = 8,
  parameter int SLICES  = 8,
  localparam int DW     = SLICE_W * SLICES,
  localparam int IDXW   = $clog2(SLICES),
  localparam int SZW    = $clog2(IDXW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [SZW-1:0]    lane_size_i,
  input  logic              sub_i,
  input  logic              sat_i,
  input  logic              signed_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  output logic              valid_o,
  output logic [DW-1:0]     result_o,
  output logic [SLICES-1:0] sat_flags_o
);
  lane_sz_e          size_e;
  logic [IDXW-1:0]   lmask;
  logic [SLICES-1:0] start_w, cin_w, cout_w, ovf_w, dhi_w;
  logic [DW-1:0]     sum_w, res_w;
  logic [SLICES-1:0] flg_w;

  always_comb begin
    size_e = lane_sz_e'(lane_size_i);
    lmask  = IDXW'((1 << size_e) - 1);
  end

  // Split carry chain: a slice starting a lane takes the operation's carry-in.
  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    assign start_w[i] = ((IDXW'(i) & lmask) == '0);
    if (i == 0) begin : g_first
      assign cin_w[i] = sub_i;
    end else begin : g_rest
      assign cin_w[i] = start_w[i] ? sub_i : cout_w[i-1];
    end

    simd_byte_slice #(.SW(SLICE_W)) u_slice (
      .a    (a_i[i*SLICE_W +: SLICE_W]),
      .b    (b_i[i*SLICE_W +: SLICE_W]),
      .inv  (sub_i),
      .cin  (cin_w[i]),
      .sum  (sum_w[i*SLICE_W +: SLICE_W]),
      .cout (cout_w[i])
    );

    simd_lane_sat u_sat (
      .a_msb  (a_i[i*SLICE_W + SLICE_W - 1]),
      .b_msb  (b_i[i*SLICE_W + SLICE_W - 1]),
      .r_msb  (sum_w[i*SLICE_W + SLICE_W - 1]),
      .cout   (cout_w[i]),
      .sub    (sub_i),
      .sgn    (signed_i),
      .ovf    (ovf_w[i]),
      .dir_hi (dhi_w[i])
    );
  end

  // Broadcast the lane decision from its top slice to every slice of the lane.
  always_comb begin
    for (int i = 0; i < SLICES; i++) begin
      logic [IDXW-1:0] top;
      logic            clamp, hi, is_top;
      top    = IDXW'(i) | lmask;
      clamp  = sat_i & ovf_w[top];
      hi     = dhi_w[top];
      is_top = (IDXW'(i) == top);
      if (!clamp)
        res_w[i*SLICE_W +: SLICE_W] = sum_w[i*SLICE_W +: SLICE_W];
      else if (is_top && signed_i)
        res_w[i*SLICE_W +: SLICE_W] = {~hi, {(SLICE_W-1){hi}}};
      else
        res_w[i*SLICE_W +: SLICE_W] = {SLICE_W{hi}};
    end
    for (int k = 0; k < SLICES; k++) begin
      flg_w[k] = 1'b0;
      if (k < (SLICES >> size_e))
        flg_w[k] = sat_i & ovf_w[IDXW'((k << size_e) | int'(lmask))];
    end
  end

  logic [SZW-1:0] size_q;
  logic           sat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      sat_flags_o <= '0;
      size_q      <= '0;
      sat_q       <= 1'b0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o    <= res_w;
        sat_flags_o <= flg_w;
        size_q      <= lane_size_i;
        sat_q       <= sat_i;
      end
    end
  end

  logic [SLICES-1:0] act_q;
  always_comb begin
    for (int k = 0; k < SLICES; k++)
      act_q[k] = (k < (SLICES >> size_q));
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> valid_o);
  a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !valid_o);
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> ($stable(result_o) && $stable(sat_flags_o)));
  a_r8_unused_lanes_zero: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((sat_flags_o & ~act_q) == '0));
  a_r8_wrap_no_flags: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !sat_q) |-> (sat_flags_o == '0));
  a_r8_quad_single_flag: assert property (@(posedge clk) disable iff (rst)
    (valid_o && size_q == SZW'(IDXW)) |-> $onehot0(sat_flags_o));
endmodule

// File: tb/simd_addsub_bench.sv
`timescale 1ns/1ps
module simd_addsub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [1:0]  lane_size_i = '0;
  logic        sub_i = 1'b0, sat_i = 1'b0, signed_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [7:0]  sat_flags_o;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  simd_addsub u_simd_addsub (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .lane_size_i(lane_size_i),
    .sub_i(sub_i), .sat_i(sat_i), .signed_i(signed_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o), .sat_flags_o(sat_flags_o)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic        sub;
    logic        sat;
    logic        sgn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic [7:0]  f;
  } vec_t;

  // sz: 0=8b 1=16b 2=32b 3=64b lanes (R1); sub (R2); sat (R4 R5 R6); sgn
  localparam vec_t VECS [13] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 64'hFF01020304050607, 64'h0101010101010101, 64'h0002030405060708, 8'h00},
    '{2'd0, 1'b0, 1'b0, 1'b0, 64'h00000000000000FF, 64'h0000000000000001, 64'h0000000000000000, 8'h00},
    '{2'd3, 1'b0, 1'b0, 1'b0, 64'h00000000000000FF, 64'h0000000000000001, 64'h0000000000000100, 8'h00},
    '{2'd1, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 64'h0000000000000001, 64'h000000000000FFFF, 8'h00},
    '{2'd0, 1'b0, 1'b1, 1'b0, 64'h8010FF007F01C020, 64'h8010010001015020, 64'hFF20FF008002FF40, 8'hA2},
    '{2'd0, 1'b0, 1'b1, 1'b1, 64'h8010FF007F01C020, 64'h8010010001015020, 64'h802000007F021040, 8'h88},
    '{2'd1, 1'b1, 1'b1, 1'b0, 64'h00051000FFFF0000, 64'h00060FFF00010001, 64'h00000001FFFE0000, 8'h09},
    '{2'd1, 1'b1, 1'b1, 1'b1, 64'h80007FFF0001FFFF, 64'h0001FFFF00027FFF, 64'h80007FFFFFFF8000, 8'h0C},
    '{2'd2, 1'b0, 1'b1, 1'b1, 64'h7FFFFFFF0000FFFF, 64'h0000000100000001, 64'h7FFFFFFF00010000, 8'h02},
    '{2'd2, 1'b0, 1'b0, 1'b0, 64'h7FFFFFFF0000FFFF, 64'h0000000100000001, 64'h8000000000010000, 8'h00},
    '{2'd3, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 8'h01},
    '{2'd3, 1'b1, 1'b1, 1'b1, 64'h8000000000000000, 64'h0000000000000001, 64'h8000000000000000, 8'h01},
    '{2'd0, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 64'h0101010101010101, 64'hFFFFFFFFFFFFFFFF, 8'h00}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic [63:0] held_r;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 valid after reset", {63'b0, valid_o}, 64'd0);
    check("R9 result after reset", result_o, 64'd0);
    check("R9 flags after reset", {56'b0, sat_flags_o}, 64'd0);
    rst = 1'b0;

    // Table: R1 R2 R3 R4 R5 R6 result, R8 flags, R7 one-clock latency
    for (int v = 0; v < 13; v++) begin
      @(negedge clk);
      lane_size_i = VECS[v].sz; sub_i = VECS[v].sub; sat_i = VECS[v].sat;
      signed_i = VECS[v].sgn; a_i = VECS[v].a; b_i = VECS[v].b;
      in_valid_i = 1'b1;
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 R5 R6 vector %0d result", v), result_o, VECS[v].r);
      check($sformatf("R8 vector %0d flags", v), {56'b0, sat_flags_o}, {56'b0, VECS[v].f});
      check($sformatf("R7 vector %0d valid", v), {63'b0, valid_o}, 64'd1);
    end

    // R7: strobe low, changed operands must not reach the outputs
    held_r = result_o;
    @(negedge clk);
    in_valid_i = 1'b0; a_i = 64'h1234567812345678; b_i = 64'h1111111111111111;
    sat_i = 1'b1; lane_size_i = 2'd0;
    @(negedge clk);
    check("R7 valid low when idle", {63'b0, valid_o}, 64'd0);
    check("R7 result held when idle", result_o, held_r);
    check("R7 flags held when idle", {56'b0, sat_flags_o}, 64'd0);

    // R8: signed byte clamp, flag lands on each lane
    @(negedge clk);
    in_valid_i = 1'b1; sub_i = 1'b0; sat_i = 1'b1; signed_i = 1'b1; lane_size_i = 2'd0;
    a_i = 64'h7F7F7F7F7F7F7F7F; b_i = 64'h0101010101010101;
    @(negedge clk);
    check("R6 all bytes clamp high", result_o, 64'h7F7F7F7F7F7F7F7F);
    check("R8 all byte flags", {56'b0, sat_flags_o}, 64'hFF);

    // R9: reset mid-run clears outputs
    @(negedge clk);
    in_valid_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R9 result cleared", result_o, 64'd0);
    check("R9 flags cleared", {56'b0, sat_flags_o}, 64'd0);
    check("R9 valid cleared", {63'b0, valid_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule